// File: doc/BRIEF.md
# Conditional Branch Evaluation Unit

This unit decides the control-flow outcome of one jump-class instruction per clock for a 64-bit register machine. Each valid cycle it receives a four-bit operation code, a flag selecting the 32-bit compare mode, the destination register value, the source register value, a 32-bit immediate, a source-select bit, the current program counter and a signed 16-bit word offset.

One cycle later it presents its result. This is a taken flag and the next program counter. For a call it raises a call flag with the immediate as the function identifier. For a return it raises an exit flag. An operation that is illegal in the selected mode raises an illegal flag. The second operand comes either from the source register or from the immediate, which is sign-extended to 64 bits.

The unit provides an unconditional jump, equality and inequality tests, a bit-test, and both unsigned and signed ordered compares. It only flags calls and exits; carrying them out is left to the surrounding pipeline. Its results are held until the next valid cycle.

Top module: `br_eval_unit`

## Requirements
- R1: While reset is asserted and after its release, until the first valid input, all outputs are zero.
- R2: When the source-select bit is 1, the second operand is the source register value. When it is 0, the second operand is the 32-bit immediate sign-extended to 64 bits.
- R3: Code 0x1 branches on equal operands and code 0x5 on unequal ones. Code 0x4 branches when the bitwise AND of the operands is nonzero.
- R4: Unsigned compares branch when the destination is greater (0x2), greater-or-equal (0x3), less (0xa) or less-or-equal (0xb) relative to the second operand.
- R5: Signed two's-complement compares branch when the destination is greater (0x6), greater-or-equal (0x7), less (0xc) or less-or-equal (0xd).
- R6: In 32-bit mode only bits 31:0 of both operands take part, and the sign is taken from bit 31.
- R7: A taken branch gives next PC = PC + 1 + sign-extended offset, modulo 2^PC_W. Every other outcome gives PC + 1.
- R8: Code 0x0 in 64-bit mode is always taken.
- R9: Code 0x8 in 64-bit mode raises the call flag and outputs the immediate as the call identifier. The branch is not taken and the next PC is PC + 1.
- R10: Code 0x9 in 64-bit mode raises the exit flag. The branch is not taken and the next PC is PC + 1.
- R11: Codes 0x0, 0x8 and 0x9 in 32-bit mode, and codes 0xe and 0xf in either mode, raise the illegal flag only, with taken, call and exit all 0. At most one of taken, call, exit and illegal is ever 1.
- R12: The output valid flag follows the input valid flag one cycle later. Results update only on a valid input and are otherwise held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 4 | Branch operation code |
| in_narrow | input | 1 | 1 = 32-bit compare mode |
| in_src_reg | input | 1 | 1 = second operand from source register |
| in_dst_val | input | 64 | Destination register value |
| in_src_val | input | 64 | Source register value |
| in_imm | input | 32 | Immediate, also the call identifier |
| in_pc | input | 32 | Current program counter in instruction words |
| in_off | input | 16 | Signed branch offset in words |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 32 | Next program counter |
| out_call | output | 1 | Call requested |
| out_call_id | output | 32 | Function identifier of the call |
| out_exit | output | 1 | Function return requested |
| out_illegal | output | 1 | Operation illegal in this mode |

## Verification
The bench uses the default parameters: DATA_W=64, NARROW_W=32, IMM_W=32, PC_W=32 and OFF_W=16. With a 32-bit counter, target wrap-around at 2^32 can be driven directly from the all-ones PC. With 64-bit operands, the bench can supply values whose upper half differs while the lower 32 bits match. This exposes 32-bit mode as a separate compare lane. It also lets a sign bit at position 31 or 63 give opposite signed and unsigned results.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [3:0] {
    BR_ALWAYS = 4'h0,
    BR_EQ     = 4'h1,
    BR_UGT    = 4'h2,
    BR_UGE    = 4'h3,
    BR_TEST   = 4'h4,
    BR_NE     = 4'h5,
    BR_SGT    = 4'h6,
    BR_SGE    = 4'h7,
    BR_CALL   = 4'h8,
    BR_EXIT   = 4'h9,
    BR_ULT    = 4'ha,
    BR_ULE    = 4'hb,
    BR_SLT    = 4'hc,
    BR_SLE    = 4'hd
  } br_op_e;

  typedef struct packed {
    logic eq;
    logic ult;
    logic ugt;
    logic slt;
    logic sgt;
    logic anyset;
  } cmp_flags_t;

endpackage

// File: rtl/br_cmp.sv
module br_cmp
  import br_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmp_flags_t   flags
);

  always_comb begin
    flags.eq     = (a == b);
    flags.ult    = (a < b);
    flags.ugt    = (a > b);
    flags.slt    = ($signed(a) < $signed(b));
    flags.sgt    = ($signed(a) > $signed(b));
    flags.anyset = |(a & b);
  end

  // exactly one ordering relation holds in each family
  always_comb begin
    if (!$isunknown({a, b})) begin
      assert_unsigned_order_R4: assert ($onehot({flags.ult, flags.eq, flags.ugt}))
        else $error("unsigned ordering flags not one-hot");
      assert_signed_order_R5: assert ($onehot({flags.slt, flags.eq, flags.sgt}))
        else $error("signed ordering flags not one-hot");
    end
  end

endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic             take,
  output logic [PC_W-1:0]  nxt
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] jmp_pc;

  always_comb begin
    seq_pc  = pc + {{(PC_W-1){1'b0}}, 1'b1};
    off_ext = {{EXT_W{off[OFF_W-1]}}, off};
    jmp_pc  = seq_pc + off_ext;
    nxt     = take ? jmp_pc : seq_pc;
  end

endmodule

// File: rtl/br_eval_unit.sv
module br_eval_unit
  import br_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IMM_W    = 32,
  parameter int PC_W     = 32,
  parameter int OFF_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic              in_narrow,
  input  logic              in_src_reg,
  input  logic [DATA_W-1:0] in_dst_val,
  input  logic [DATA_W-1:0] in_src_val,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [OFF_W-1:0]  in_off,
  output logic              out_valid,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_call,
  output logic [IMM_W-1:0]  out_call_id,
  output logic              out_exit,
  output logic              out_illegal
);

  localparam int IMM_EXT = DATA_W - IMM_W;
  localparam int LANES   = 2;

  logic [DATA_W-1:0] opnd_b;
  cmp_flags_t        lane_flags [LANES];
  cmp_flags_t        cf;
  br_op_e            op_e;
  logic              cond_d, call_d, exit_d, bad_d;
  logic [PC_W-1:0]   next_pc_d;

  assign opnd_b = in_src_reg ? in_src_val
                             : {{IMM_EXT{in_imm[IMM_W-1]}}, in_imm};

  // lane 0 compares full width, lane 1 the narrow low part
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? DATA_W : NARROW_W;
    br_cmp #(.W(LW)) u_cmp (
      .a     (in_dst_val[LW-1:0]),
      .b     (opnd_b[LW-1:0]),
      .flags (lane_flags[g])
    );
  end

  always_comb begin
    cf     = in_narrow ? lane_flags[1] : lane_flags[0];
    op_e   = br_op_e'(in_op);
    cond_d = 1'b0;
    call_d = 1'b0;
    exit_d = 1'b0;
    bad_d  = 1'b0;
    case (op_e)
      BR_ALWAYS: if (in_narrow) bad_d = 1'b1; else cond_d = 1'b1;
      BR_EQ:     cond_d = cf.eq;
      BR_NE:     cond_d = !cf.eq;
      BR_TEST:   cond_d = cf.anyset;
      BR_UGT:    cond_d = cf.ugt;
      BR_UGE:    cond_d = cf.ugt | cf.eq;
      BR_ULT:    cond_d = cf.ult;
      BR_ULE:    cond_d = cf.ult | cf.eq;
      BR_SGT:    cond_d = cf.sgt;
      BR_SGE:    cond_d = cf.sgt | cf.eq;
      BR_SLT:    cond_d = cf.slt;
      BR_SLE:    cond_d = cf.slt | cf.eq;
      BR_CALL:   if (in_narrow) bad_d = 1'b1; else call_d = 1'b1;
      BR_EXIT:   if (in_narrow) bad_d = 1'b1; else exit_d = 1'b1;
      default:   bad_d = 1'b1;
    endcase
  end

  br_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
    .pc   (in_pc),
    .off  (in_off),
    .take (cond_d),
    .nxt  (next_pc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_taken   <= 1'b0;
      out_next_pc <= '0;
      out_call    <= 1'b0;
      out_call_id <= '0;
      out_exit    <= 1'b0;
      out_illegal <= 1'b0;
    end else if (in_valid) begin
      out_taken   <= cond_d;
      out_next_pc <= next_pc_d;
      out_call    <= call_d;
      out_call_id <= in_imm;
      out_exit    <= exit_d;
      out_illegal <= bad_d;
    end
  end

  assert_outcome_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_taken, out_call, out_exit, out_illegal}))
    else $error("more than one outcome flag set");

  assert_narrow_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_narrow && (in_op == 4'h0 || in_op == 4'h8 || in_op == 4'h9))
    |=> out_illegal)
    else $error("narrow mode accepted a wide-only code");

  assert_seq_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_taken) |->
    (out_next_pc == $past(in_pc) + {{(PC_W-1){1'b0}}, 1'b1}))
    else $error("not-taken next pc is not pc+1");

  assert_call_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_call |-> (out_call_id == $past(in_imm)))
    else $error("call id differs from immediate");

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_taken) && $stable(out_next_pc) && $stable(out_illegal)))
    else $error("results changed without valid input");

endmodule

// File: tb/sim_br_eval_unit.sv
`timescale 1ns/1ps
module sim_br_eval_unit;

  typedef struct packed {
    logic [3:0]  op;
    logic        nar;
    logic        sreg;
    logic [63:0] dst;
    logic [63:0] src;
    logic [31:0] imm;
    logic [15:0] off;
    logic [3:0]  exp;   // {taken, call, exit, illegal}
  } vec_t;

  localparam int NV = 24;
  localparam logic [185:0] VEC [0:NV-1] = '{
    {4'h0, 1'b0, 1'b1, 64'h0, 64'h0, 32'h0, 16'h0005, 4'b1000},                                  // R8 always
    {4'h1, 1'b0, 1'b1, 64'd5, 64'd5, 32'h0, 16'hfffd, 4'b1000},                                  // R3 eq, negative off R7
    {4'h1, 1'b0, 1'b0, 64'hffff_ffff_ffff_ffff, 64'h0, 32'hffff_ffff, 16'h0010, 4'b1000},        // R2 sext imm
    {4'h1, 1'b0, 1'b1, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_ffff_ffff, 32'hffff_ffff, 16'h0010, 4'b0000}, // R2 register
    {4'h5, 1'b0, 1'b1, 64'd1, 64'd2, 32'h0, 16'h0020, 4'b1000},                                  // R3 ne
    {4'h4, 1'b0, 1'b1, 64'hf0, 64'h0f, 32'h0, 16'h0020, 4'b0000},                                // R3 test miss
    {4'h4, 1'b0, 1'b1, 64'h18, 64'h10, 32'h0, 16'h0020, 4'b1000},                                // R3 test hit
    {4'h2, 1'b0, 1'b1, 64'hffff_ffff_ffff_ffff, 64'd1, 32'h0, 16'h0004, 4'b1000},                // R4 ugt
    {4'h6, 1'b0, 1'b1, 64'hffff_ffff_ffff_ffff, 64'd1, 32'h0, 16'h0004, 4'b0000},                // R5 sgt
    {4'h3, 1'b0, 1'b1, 64'd7, 64'd7, 32'h0, 16'h0004, 4'b1000},                                  // R4 uge
    {4'h7, 1'b0, 1'b1, 64'd1, 64'hffff_ffff_ffff_ffff, 32'h0, 16'h0004, 4'b1000},                // R5 sge
    {4'ha, 1'b0, 1'b1, 64'd3, 64'd4, 32'h0, 16'h0008, 4'b1000},                                  // R4 ult
    {4'hb, 1'b0, 1'b1, 64'd5, 64'd4, 32'h0, 16'h0008, 4'b0000},                                  // R4 ule
    {4'hc, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h0, 32'h0, 16'h0008, 4'b1000},                // R5 slt
    {4'hd, 1'b0, 1'b1, 64'h0, 64'h8000_0000_0000_0000, 32'h0, 16'h0008, 4'b0000},                // R5 sle
    {4'h1, 1'b1, 1'b1, 64'h1234_5678_0000_0009, 64'h9999_0000_0000_0009, 32'h0, 16'h0030, 4'b1000}, // R6 eq low
    {4'h6, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'd1, 32'h0, 16'h0030, 4'b0000},                // R6 sign bit 31
    {4'h2, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'd1, 32'h0, 16'h0030, 4'b1000},                // R6 unsigned
    {4'h8, 1'b0, 1'b0, 64'h0, 64'h0, 32'h0000_002a, 16'h0030, 4'b0100},                          // R9 call
    {4'h9, 1'b0, 1'b0, 64'h0, 64'h0, 32'h0, 16'h0030, 4'b0010},                                  // R10 exit
    {4'h0, 1'b1, 1'b0, 64'h0, 64'h0, 32'h0, 16'h0030, 4'b0001},                                  // R11 narrow always
    {4'h8, 1'b1, 1'b0, 64'h0, 64'h0, 32'h0, 16'h0030, 4'b0001},                                  // R11 narrow call
    {4'h9, 1'b1, 1'b0, 64'h0, 64'h0, 32'h0, 16'h0030, 4'b0001},                                  // R11 narrow exit
    {4'he, 1'b0, 1'b1, 64'h0, 64'h0, 32'h0, 16'h0030, 4'b0001}                                   // R11 undefined code
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic        in_narrow = 1'b0;
  logic        in_src_reg = 1'b0;
  logic [63:0] in_dst_val = '0;
  logic [63:0] in_src_val = '0;
  logic [31:0] in_imm = '0;
  logic [31:0] in_pc = '0;
  logic [15:0] in_off = '0;
  logic        out_valid, out_taken, out_call, out_exit, out_illegal;
  logic [31:0] out_next_pc, out_call_id;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  br_eval_unit u0 (
    .clk, .rst_n, .in_valid, .in_op, .in_narrow, .in_src_reg,
    .in_dst_val, .in_src_val, .in_imm, .in_pc, .in_off,
    .out_valid, .out_taken, .out_next_pc, .out_call, .out_call_id,
    .out_exit, .out_illegal
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] tgt(input logic [31:0] pc, input logic [15:0] off, input logic t);
    return t ? pc + 32'd1 + {{16{off[15]}}, off} : pc + 32'd1;
  endfunction

  task automatic drive(input vec_t v, input logic [31:0] pc);
    in_valid   = 1'b1;
    in_op      = v.op;
    in_narrow  = v.nar;
    in_src_reg = v.sreg;
    in_dst_val = v.dst;
    in_src_val = v.src;
    in_imm     = v.imm;
    in_off     = v.off;
    in_pc      = pc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t v;
    logic [31:0] pc;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check("R1 reset outputs", {out_valid, out_taken, out_call, out_exit, out_illegal, out_next_pc, out_call_id},
          '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {out_valid, out_taken, out_call, out_exit, out_illegal, out_next_pc}, '0);

    for (int i = 0; i < NV; i++) begin
      v  = vec_t'(VEC[i]);
      pc = 32'd1000 + 32'(i) * 32'd7;
      drive(v, pc);
      @(negedge clk);
      check($sformatf("R12 valid vec %0d", i), out_valid, 1'b1);
      check($sformatf("R3-6,8-11 flags vec %0d", i),
            {out_taken, out_call, out_exit, out_illegal}, v.exp);
      check($sformatf("R7 next pc vec %0d", i), out_next_pc, tgt(pc, v.off, v.exp[3]));
      if (v.exp[2]) check($sformatf("R9 call id vec %0d", i), out_call_id, v.imm);
    end

    // R7 wrap of taken target
    v = vec_t'(VEC[0]);
    v.off = 16'h0000;
    drive(v, 32'hffff_ffff);
    @(negedge clk);
    check("R7 wrap target", out_next_pc, 32'h0);
    v.off = 16'hfffd;
    drive(v, 32'd2);
    @(negedge clk);
    check("R7 negative offset to zero", out_next_pc, 32'h0);

    // R12 hold while idle, new inputs ignored
    v = vec_t'(VEC[0]);
    v.off = 16'h0040;
    drive(v, 32'd500);
    @(negedge clk);
    in_valid = 1'b0;
    in_op    = 4'he;
    in_pc    = 32'd9;
    @(negedge clk);
    check("R12 valid drops", out_valid, 1'b0);
    check("R12 held taken", {out_taken, out_illegal}, 2'b10);
    @(negedge clk);
    check("R12 held pc", out_next_pc, 32'd565);

    // R1 reset mid-stream clears results
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", {out_taken, out_next_pc}, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule